// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data in both directions between a narrow port A and a wide port B. Port B is split into two equal halves, B1 and B2. Going from A to B, two narrow words that arrive one after the other are collected and then presented together as one wide word. The B1 path has two register stages and the B2 path has one. Driving the load strobes in a staggered pattern lines the two words up on the same clock edge. Going from B to A, each half of the wide bus is captured in its own register, and a select input picks which of the two drives A.

Every storage register loads on a rising clock edge only while its active-low load strobe is low. The requests that turn each port's drivers on are also registered. A change of bus direction therefore always takes effect on a clock edge. These registered requests form a four-state direction machine:
- DIR_IDLE: neither port drives.
- DIR_TO_A: only A drives.
- DIR_TO_B: only B drives.
- DIR_BOTH: both ports drive.

Each edge moves the machine to the state named by the sampled pair of requests. Any state can reach any other state, and each transition is named after the state it enters. Each port is modelled as separate input, output and per-bit output-enable vectors.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising edge, every data register clears to zero and the direction machine enters DIR_IDLE, with both enable vectors all zero.
- R2: A register whose active-low load strobe is high at an edge keeps its value. With `ld_a1_n` and `ld_a2_n` both high, `b1_out` and `b2_out` stay unchanged.
- R3: The A-to-B1 path is two registers in series, both loaded by `ld_a1_n`. A word on `a_in` reaches `b1_out` after two edges with `ld_a1_n` low.
- R4: The A-to-B2 path is one register loaded by `ld_a2_n`. A word on `a_in` appears on `b2_out` right after one edge with `ld_a2_n` low.
- R5: Gathering works as follows. In the first cycle, word W1 is on A with `ld_a1_n` low and `ld_a2_n` high. In the next cycle, W2 is on A with both strobes low. After that edge, `b1_out` is W1 and `b2_out` is W2.
- R6: The B1 capture register loads `b1_in` on an edge with `ld_b1_n` low. The B2 capture register loads `b2_in` on an edge with `ld_b2_n` low.
- R7: `a_out` shows the B1 capture register when `hi_sel` is 1 and the B2 capture register when `hi_sel` is 0. The path from `hi_sel` to `a_out` has no register in it.
- R8: `a_oe` becomes all ones on the edge after `a_oe_n` is sampled low, and all zeros on the edge after it is sampled high. `b1_oe` and `b2_oe` follow `b_oe_n` in the same way.
- R9: Both ports may drive at once (DIR_BOTH), and a change of `hi_sel` has no effect on any enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | NW | Narrow port input data |
| a_out | output | NW | Narrow port output data |
| a_oe | output | NW | Narrow port per-bit drive enable |
| b1_in | input | NW | Wide port lower-half input |
| b2_in | input | NW | Wide port upper-half input |
| b1_out | output | NW | Wide port lower-half output |
| b2_out | output | NW | Wide port upper-half output |
| b1_oe | output | NW | Lower-half drive enable |
| b2_oe | output | NW | Upper-half drive enable |
| ld_a1_n | input | 1 | Load strobe for both A-to-B1 stages, active low |
| ld_a2_n | input | 1 | Load strobe for the A-to-B2 register, active low |
| ld_b1_n | input | 1 | Load strobe for the B1 capture register, active low |
| ld_b2_n | input | 1 | Load strobe for the B2 capture register, active low |
| hi_sel | input | 1 | 1 selects B1 capture onto A, 0 selects B2 |
| a_oe_n | input | 1 | Drive request for port A, active low, registered |
| b_oe_n | input | 1 | Drive request for port B, active low, registered |

## Verification
Within one cycle, a capture into a B-side register can coincide with a switch of `hi_sel`, and a direction-machine change can coincide with the same edge. The bench sweeps all 128 combinations of the seven control inputs, each with fresh data, and compares every output against an arithmetic model after each edge. That model updates both register paths and the enable pair together. A mis-ordered or cross-wired update therefore shows up as a mismatch on `a_out` or an enable vector in that same cycle. Directed sequences then check the two-edge and one-edge latencies, the gathering order, and reset.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;
    typedef enum logic [1:0] {
        DIR_IDLE = 2'b00,
        DIR_TO_A = 2'b01,
        DIR_TO_B = 2'b10,
        DIR_BOTH = 2'b11
    } xchg_dir_e;
endpackage

// File: rtl/xchg_stage.sv
module xchg_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (!load_n)
            q <= d;
    end
endmodule

// File: rtl/xchg_dir_fsm.sv
module xchg_dir_fsm
    import bus_exchanger_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_req_n,
    input  logic b_req_n,
    output logic a_drive,
    output logic b_drive
);
    xchg_dir_e state_q;
    xchg_dir_e state_d;

    // next state named by the sampled request pair
    always_comb begin
        unique case ({!b_req_n, !a_req_n})
            2'b00:   state_d = DIR_IDLE;
            2'b01:   state_d = DIR_TO_A;
            2'b10:   state_d = DIR_TO_B;
            default: state_d = DIR_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= DIR_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DIR_IDLE: begin a_drive = 1'b0; b_drive = 1'b0; end
            DIR_TO_A: begin a_drive = 1'b1; b_drive = 1'b0; end
            DIR_TO_B: begin a_drive = 1'b0; b_drive = 1'b1; end
            default:  begin a_drive = 1'b1; b_drive = 1'b1; end
        endcase
    end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger #(
    parameter int NW        = 12,
    parameter int A1_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] a_in,
    output logic [NW-1:0] a_out,
    output logic [NW-1:0] a_oe,
    input  logic [NW-1:0] b1_in,
    input  logic [NW-1:0] b2_in,
    output logic [NW-1:0] b1_out,
    output logic [NW-1:0] b2_out,
    output logic [NW-1:0] b1_oe,
    output logic [NW-1:0] b2_oe,
    input  logic          ld_a1_n,
    input  logic          ld_a2_n,
    input  logic          ld_b1_n,
    input  logic          ld_b2_n,
    input  logic          hi_sel,
    input  logic          a_oe_n,
    input  logic          b_oe_n
);
    localparam int WW = 2 * NW;

    logic [NW-1:0] a1_chain [A1_STAGES+1];
    logic [NW-1:0] cap_b1;
    logic [NW-1:0] cap_b2;
    logic [WW-1:0] wide_q;
    logic          a_drive;
    logic          b_drive;

    assign a1_chain[0] = a_in;

    // A-to-B1: staged pipeline sharing one load strobe
    for (genvar g = 0; g < A1_STAGES; g++) begin : g_a1
        xchg_stage #(.W(NW)) stage_i (
            .clk(clk), .rst(rst), .load_n(ld_a1_n),
            .d(a1_chain[g]), .q(a1_chain[g+1])
        );
    end

    // A-to-B2: single register
    xchg_stage #(.W(NW)) a2_i (
        .clk(clk), .rst(rst), .load_n(ld_a2_n), .d(a_in), .q(wide_q[WW-1:NW])
    );
    assign wide_q[NW-1:0] = a1_chain[A1_STAGES];

    // B-to-A capture registers
    xchg_stage #(.W(NW)) b1cap_i (
        .clk(clk), .rst(rst), .load_n(ld_b1_n), .d(b1_in), .q(cap_b1)
    );
    xchg_stage #(.W(NW)) b2cap_i (
        .clk(clk), .rst(rst), .load_n(ld_b2_n), .d(b2_in), .q(cap_b2)
    );

    xchg_dir_fsm dir_i (
        .clk(clk), .rst(rst), .a_req_n(a_oe_n), .b_req_n(b_oe_n),
        .a_drive(a_drive), .b_drive(b_drive)
    );

    assign a_out  = hi_sel ? cap_b1 : cap_b2;
    assign b1_out = wide_q[NW-1:0];
    assign b2_out = wide_q[WW-1:NW];
    assign a_oe   = {NW{a_drive}};
    assign b1_oe  = {NW{b_drive}};
    assign b2_oe  = {NW{b_drive}};
endmodule

// File: rtl/bus_exchanger_chk.sv
module bus_exchanger_chk #(
    parameter int NW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [NW-1:0] a_in,
    input logic [NW-1:0] a_out,
    input logic [NW-1:0] a_oe,
    input logic [NW-1:0] b1_in,
    input logic [NW-1:0] b1_out,
    input logic [NW-1:0] b2_out,
    input logic [NW-1:0] b1_oe,
    input logic          ld_a1_n,
    input logic          ld_a2_n,
    input logic          ld_b1_n,
    input logic          hi_sel,
    input logic          a_oe_n,
    input logic          b_oe_n
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (a_oe == '0 && b1_oe == '0 && b1_out == '0 && b2_out == '0)); // R1

    AST_HOLD_B_SIDE: assert property (@(posedge clk) disable iff (rst)
        (ld_a1_n && ld_a2_n) |=> ($stable(b1_out) && $stable(b2_out))); // R2

    AST_B1_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!ld_a1_n && $past(!ld_a1_n) && $past(!rst)) |=> (b1_out == $past(a_in, 2))); // R3

    AST_B2_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        !ld_a2_n |=> (b2_out == $past(a_in))); // R4

    AST_SEL_B1_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ($past(!ld_b1_n) && $past(!rst) && hi_sel) |-> (a_out == $past(b1_in))); // R7

    AST_A_OE_ON: assert property (@(posedge clk) disable iff (rst)
        !a_oe_n |=> (a_oe == '1)); // R8

    AST_B_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        b_oe_n |=> (b1_oe == '0)); // R8
endmodule

bind bus_exchanger bus_exchanger_chk #(.NW(NW)) chk_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b2_out(b2_out), .b1_oe(b1_oe),
    .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n), .ld_b1_n(ld_b1_n),
    .hi_sel(hi_sel), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
);

// File: tb/bus_exchanger_tb_top.sv
module bus_exchanger_tb_top;
    localparam int NW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [NW-1:0] a_out, a_oe, b1_out, b2_out, b1_oe, b2_oe;
    logic          ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
    logic          hi_sel = 1'b0, a_oe_n = 1'b1, b_oe_n = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [NW-1:0] m_s1, m_s2, m_h2, m_c1, m_c2;
    logic          m_ad, m_bd;

    always #10 clk = ~clk;

    bus_exchanger #(.NW(NW)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
        .b1_oe(b1_oe), .b2_oe(b2_oe), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
        .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n), .hi_sel(hi_sel),
        .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
    );

    task automatic chk(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: advance model with inputs held since the last negedge
    task automatic tick();
        @(posedge clk);
        #1;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_h2 = '0; m_c1 = '0; m_c2 = '0;
            m_ad = 1'b0; m_bd = 1'b0;
        end else begin
            if (!ld_a1_n) begin m_s2 = m_s1; m_s1 = a_in; end
            if (!ld_a2_n) m_h2 = a_in;
            if (!ld_b1_n) m_c1 = b1_in;
            if (!ld_b2_n) m_c2 = b2_in;
            m_ad = !a_oe_n;
            m_bd = !b_oe_n;
        end
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R3 b1_out"}, b1_out, m_s2);
        chk({ctx, " R4 b2_out"}, b2_out, m_h2);
        chk({ctx, " R7 a_out"}, a_out, hi_sel ? m_c1 : m_c2);
        chk({ctx, " R8 a_oe"}, a_oe, {NW{m_ad}});
        chk({ctx, " R9 b_oe"}, b1_oe | ~b2_oe, {NW{m_bd}} | ~{NW{m_bd}});
        chk({ctx, " R8 b1_oe"}, b1_oe, {NW{m_bd}});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [NW-1:0] w1, w2, held1, held2;
        @(negedge clk);
        a_in = 12'hA5A; ld_a1_n = 1'b0; ld_a2_n = 1'b0; a_oe_n = 1'b0; b_oe_n = 1'b0;
        tick();
        // R1: reset wins over strobes and requests
        chk("R1 b1_out", b1_out, '0);
        chk("R1 b2_out", b2_out, '0);
        chk("R1 a_oe", a_oe, '0);
        chk("R1 b2_oe", b2_oe, '0);
        @(negedge clk);
        rst = 1'b0; ld_a1_n = 1'b1; ld_a2_n = 1'b1; a_oe_n = 1'b1; b_oe_n = 1'b1;

        // R4 one edge, R3 two edges
        a_in = 12'h123; ld_a1_n = 1'b0; ld_a2_n = 1'b0;
        tick();
        chk("R4 one edge", b2_out, 12'h123);
        chk("R3 not after one edge", b1_out, 12'h000);
        @(negedge clk);
        a_in = 12'h456;
        tick();
        chk("R3 after two edges", b1_out, 12'h123);

        // R2 hold with both strobes high
        @(negedge clk);
        ld_a1_n = 1'b1; ld_a2_n = 1'b1; a_in = 12'hFFF;
        held1 = b1_out; held2 = b2_out;
        tick(); tick();
        chk("R2 hold b1", b1_out, held1);
        chk("R2 hold b2", b2_out, held2);

        // R5 gathering
        w1 = 12'h9C3; w2 = 12'h3E7;
        @(negedge clk);
        a_in = w1; ld_a1_n = 1'b0; ld_a2_n = 1'b1;
        tick();
        @(negedge clk);
        a_in = w2; ld_a1_n = 1'b0; ld_a2_n = 1'b0;
        tick();
        chk("R5 gathered low half", b1_out, w1);
        chk("R5 gathered high half", b2_out, w2);

        // R6/R7 capture and combinational select
        @(negedge clk);
        ld_a1_n = 1'b1; ld_a2_n = 1'b1;
        b1_in = 12'h1B1; b2_in = 12'h2B2; ld_b1_n = 1'b0; ld_b2_n = 1'b0; hi_sel = 1'b1;
        tick();
        chk("R6 B1 capture", a_out, 12'h1B1);
        #3 hi_sel = 1'b0; #1;
        chk("R7 select B2 without edge", a_out, 12'h2B2);

        // R8 registered enable: visible only after the edge
        @(negedge clk);
        ld_b1_n = 1'b1; ld_b2_n = 1'b1; a_oe_n = 1'b0;
        #2 chk("R8 a_oe before edge", a_oe, '0);
        tick();
        chk("R8 a_oe after edge", a_oe, '1);
        @(negedge clk);
        b_oe_n = 1'b0;
        tick();
        chk("R9 both drive A", a_oe, '1);
        chk("R9 both drive B", b2_oe, '1);

        // exhaustive control sweep with fresh data each combination
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            {ld_a1_n, ld_a2_n, ld_b1_n, ld_b2_n, hi_sel, a_oe_n, b_oe_n} = 7'(k);
            a_in  = 12'((k * 37 + 11) & 12'hFFF);
            b1_in = 12'((k * 91 + 5) & 12'hFFF);
            b2_in = 12'((k * 53 + 700) & 12'hFFF);
            tick();
            check_all("sweep");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule